// File: doc/BRIEF.md
# Comparator-Synchronised Pulse Generator

This block produces a single timed pulse on one output line, meant to drive the gate of a power switch. A pulse is started by one of two sync sources. In command mode, software writes a fire bit. In continuous mode, every falling edge on a digital trigger comparator input starts a pulse. Once started, the pulse is measured on a counter that begins at the sync event. The output turns on when the counter reaches a programmable start delay and turns off when it reaches a programmable end time.

Two more comparator inputs can stop a pulse early. A rising edge on the cut input ends only the pulse in progress and raises a sticky cut flag; the next sync event produces a normal pulse. A rising edge on the kill input drops the output at once and raises a sticky kill flag. While the kill flag is set, no pulse can start. Software clears either flag through the register bus.

All three comparator inputs pass through a two-flop synchroniser before edge detection. The output polarity is a static build parameter.

Top module: `cmp_pulse_gen`

## Requirements
- R1: After reset, `pulse_o` is at its inactive level (0, or 1 when INVERT=1), and `cut_flag_o` and `kill_flag_o` are 0.
- R2: In command mode, a write to address 0 with bit 1 (fire) set and bit 0 (mode) clear is the sync event at write edge T. Let D be the delay register (address 1) and E the end register (address 2). `pulse_o` is active after edge T+j exactly when D <= j < E.
- R3: A write to address 0 with bit 0 set selects continuous mode. In that mode, if `trig_cmp_i` goes low before edge k, the sync event is edge k+2. The output is active after edge k+2+j exactly when D <= j < E.
- R4: With D = 0 in continuous mode, the output turns active after edge k+2. This lag comes from the synchroniser alone.
- R5: When E <= D, a sync event produces no active output at all.
- R6: A sync event that arrives while a pulse is in progress is ignored. In command mode, trigger edges are ignored.
- R7: If `cut_cmp_i` rises before edge k during a pulse, the output is inactive after edge k+2 and `cut_flag_o` is set. The next sync event gives a full normal pulse.
- R8: If `kill_cmp_i` rises before edge k, the output is inactive after edge k+2 and `kill_flag_o` is set. While the kill flag is set, no sync event produces a pulse.
- R9: A write to address 0 with bit 2 set clears `cut_flag_o`, and a write with bit 3 set clears `kill_flag_o`. After the kill flag is cleared, pulses resume normally.
- R10: With INVERT=1, `pulse_o` is the exact complement of the INVERT=0 output for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_cmp_i | input | 1 | Trigger comparator bit; a falling edge is the sync event in continuous mode |
| cut_cmp_i | input | 1 | Cycle-abort comparator bit; a rising edge ends the current pulse |
| kill_cmp_i | input | 1 | Forced-off comparator bit; a rising edge latches the output off |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 start delay, 2 end time |
| wr_data_i | input | CW | Register write data |
| pulse_o | output | 1 | Pulse output, polarity set by INVERT |
| cut_flag_o | output | 1 | Sticky cycle-abort flag |
| kill_flag_o | output | 1 | Sticky forced-off flag |

## Verification
A wrong count or a wrong window compare shows up as an output edge that is one or more cycles early or late relative to the sync edge. Every delay and end pair in a small range is swept in both modes, and every cycle of each pulse is sampled, so an off-by-one appears within the first pulse. A stuck busy state shows within a few cycles. It appears as either a missing second pulse after a cut, or an extra pulse when the trigger toggles mid-pulse. A kill flag that fails to hold is exposed by firing while the flag is still set.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DLY  = 2'd1,
        REG_END  = 2'd2
    } reg_sel_e;

    // bit positions inside the control word
    localparam int CTL_MODE     = 0;
    localparam int CTL_FIRE     = 1;
    localparam int CTL_CLR_CUT  = 2;
    localparam int CTL_CLR_KILL = 3;

    // comparator bundle; index order matches the synchroniser lanes
    typedef struct packed {
        logic kill;
        logic cut;
        logic trig;
    } cmp_bits_t;

    localparam int NCMP = 3;

    // lanes whose sync event is a falling edge (trigger only)
    localparam logic [NCMP-1:0] FALL_LANES = 3'b001;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic logic in_window(input logic [15:0] t,
                                       input logic [15:0] d,
                                       input logic [15:0] e);
        return (t >= d) && (t < e);
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] FALL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] edge_o
);
    localparam int TAPS = STAGES + 1;

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [TAPS-1:0] sh;
        logic            lvl;
        logic            prev;

        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[TAPS-2:0], din[i]};
        end

        assign lvl  = sh[STAGES-1];
        assign prev = sh[STAGES];

        if (FALL_MASK[i]) begin : g_fall
            assign edge_o[i] = prev & ~lvl;
            a_r3_fall_sees_low: assert property (@(posedge clk) disable iff (rst)
                edge_o[i] |-> ($past(din[i], STAGES) == 1'b0));
        end else begin : g_rise
            assign edge_o[i] = ~prev & lvl;
            a_r7_rise_sees_high: assert property (@(posedge clk) disable iff (rst)
                edge_o[i] |-> ($past(din[i], STAGES) == 1'b1));
        end
    end
endmodule

// File: rtl/pg_regs.sv
module pg_regs
    import pg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          cont_mode,
    output logic [CW-1:0] dly,
    output logic [CW-1:0] endt,
    output logic          fire,
    output logic          clr_cut,
    output logic          clr_kill
);
    logic ctl_wr;

    assign ctl_wr   = wr_en && (wr_addr == REG_CTRL);
    assign fire     = ctl_wr && wr_data[CTL_FIRE] && !wr_data[CTL_MODE];
    assign clr_cut  = ctl_wr && wr_data[CTL_CLR_CUT];
    assign clr_kill = ctl_wr && wr_data[CTL_CLR_KILL];

    always_ff @(posedge clk) begin
        if (rst) begin
            cont_mode <= 1'b0;
            dly       <= '0;
            endt      <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_CTRL: cont_mode <= wr_data[CTL_MODE];
                REG_DLY:  dly       <= wr_data;
                REG_END:  endt      <= wr_data;
                default:  ;
            endcase
        end
    end

    a_r2_fire_selects_command: assert property (@(posedge clk) disable iff (rst)
        fire |=> !cont_mode);
endmodule

// File: rtl/pg_core.sv
module pg_core
    import pg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          cont_mode,
    input  logic          trig_fall,
    input  logic          cut_rise,
    input  logic          kill_rise,
    input  logic [CW-1:0] dly,
    input  logic [CW-1:0] endt,
    input  logic          clr_cut,
    input  logic          clr_kill,
    output logic          on_o,
    output logic          cut_flag_o,
    output logic          kill_flag_o
);
    phase_e        ph_q;
    logic [CW-1:0] cnt_q;
    logic          on_q, cut_q, kill_q;
    logic          start;

    assign start = (ph_q == PH_IDLE) && !kill_q &&
                   (fire || (cont_mode && trig_fall));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            on_q  <= 1'b0;
        end else if (kill_rise) begin
            ph_q <= PH_IDLE;
            on_q <= 1'b0;
        end else if (cut_rise && ph_q == PH_RUN) begin
            ph_q <= PH_IDLE;
            on_q <= 1'b0;
        end else if (start) begin
            ph_q  <= (endt != '0) ? PH_RUN : PH_IDLE;
            cnt_q <= CW'(1);
            on_q  <= (dly == '0) && (endt != '0);
        end else if (ph_q == PH_RUN) begin
            cnt_q <= cnt_q + 1'b1;
            on_q  <= in_window(16'(cnt_q), 16'(dly), 16'(endt));
            if (cnt_q >= endt) ph_q <= PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cut_q  <= 1'b0;
            kill_q <= 1'b0;
        end else begin
            cut_q  <= cut_rise  | (cut_q  & ~clr_cut);
            kill_q <= kill_rise | (kill_q & ~clr_kill);
        end
    end

    assign on_o        = on_q;
    assign cut_flag_o  = cut_q;
    assign kill_flag_o = kill_q;

    a_r8_kill_holds_off: assert property (@(posedge clk) disable iff (rst)
        kill_q |-> !on_q);
    a_r7_cut_ends_pulse: assert property (@(posedge clk) disable iff (rst)
        (cut_rise && ph_q == PH_RUN) |=> !on_q);
    a_r2_on_only_running: assert property (@(posedge clk) disable iff (rst)
        on_q |-> (ph_q == PH_RUN));
    a_r5_empty_window: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_RUN && endt <= dly) |=> !on_q);
    a_r6_count_restarts: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_q == PH_RUN) |-> (cnt_q == CW'(1)));
endmodule

// File: rtl/cmp_pulse_gen.sv
module cmp_pulse_gen
    import pg_pkg::*;
#(
    parameter int   CW          = 8,
    parameter int   SYNC_STAGES = 2,
    parameter logic INVERT      = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig_cmp_i,
    input  logic          cut_cmp_i,
    input  logic          kill_cmp_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_addr_i,
    input  logic [CW-1:0] wr_data_i,
    output logic          pulse_o,
    output logic          cut_flag_o,
    output logic          kill_flag_o
);
    cmp_bits_t     cmp_in, cmp_edge;
    logic          cont_mode, fire, clr_cut, clr_kill, on_raw;
    logic [CW-1:0] dly, endt;

    assign cmp_in = '{kill: kill_cmp_i, cut: cut_cmp_i, trig: trig_cmp_i};

    pg_sync #(
        .N(NCMP), .STAGES(SYNC_STAGES), .FALL_MASK(FALL_LANES)
    ) u_sync (
        .clk(clk), .rst(rst), .din(cmp_in), .edge_o(cmp_edge)
    );

    pg_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .cont_mode(cont_mode), .dly(dly), .endt(endt),
        .fire(fire), .clr_cut(clr_cut), .clr_kill(clr_kill)
    );

    pg_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst),
        .fire(fire), .cont_mode(cont_mode),
        .trig_fall(cmp_edge.trig), .cut_rise(cmp_edge.cut),
        .kill_rise(cmp_edge.kill),
        .dly(dly), .endt(endt),
        .clr_cut(clr_cut), .clr_kill(clr_kill),
        .on_o(on_raw), .cut_flag_o(cut_flag_o), .kill_flag_o(kill_flag_o)
    );

    if (INVERT) begin : g_inv
        assign pulse_o = ~on_raw;
    end else begin : g_pass
        assign pulse_o = on_raw;
    end
endmodule

// File: tb/cmp_pulse_gen_tb.sv
module cmp_pulse_gen_tb;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b1, cut = 1'b0, kill = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          pulse, pulse_n, cflag, kflag, cflag_n, kflag_n;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    cmp_pulse_gen #(.CW(CW), .INVERT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .trig_cmp_i(trig), .cut_cmp_i(cut),
        .kill_cmp_i(kill), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .pulse_o(pulse), .cut_flag_o(cflag),
        .kill_flag_o(kflag)
    );

    cmp_pulse_gen #(.CW(CW), .INVERT(1'b1)) u_dut_inv (
        .clk(clk), .rst(rst), .trig_cmp_i(trig), .cut_cmp_i(cut),
        .kill_cmp_i(kill), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .pulse_o(pulse_n), .cut_flag_o(cflag_n),
        .kill_flag_o(kflag_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_on(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (pulse) c++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pulse idle", pulse, 0);
        chk("R1 inverted idle", pulse_n, 1);
        chk("R1 cut flag", cflag, 0);
        chk("R1 kill flag", kflag, 0);

        // R2 / R5 / R10: command-mode sweep of every delay/end pair
        for (int d = 0; d < 6; d++) begin
            for (int e = 0; e < 7; e++) begin
                wr(2'd1, CW'(d));
                wr(2'd2, CW'(e));
                wr(2'd0, 8'b0010);
                for (int j = 0; j < 9; j++) begin
                    chk((e <= d) ? "R5 empty window" : "R2 command window",
                        pulse, (j >= d && j < e) ? 1 : 0);
                    chk("R10 inverted", pulse_n, (j >= d && j < e) ? 0 : 1);
                    @(negedge clk);
                end
            end
        end

        // R3 / R4: continuous mode, trigger falling edge
        wr(2'd0, 8'b0001);
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 2; k++) begin
                int e;
                e = d + 1 + 2 * k;
                wr(2'd1, CW'(d));
                wr(2'd2, CW'(e));
                @(negedge clk);
                trig = 1'b0;
                repeat (3) @(negedge clk);
                for (int j = 0; j < 9; j++) begin
                    chk((d == 0) ? "R4 zero delay lag" : "R3 continuous window",
                        pulse, (j >= d && j < e) ? 1 : 0);
                    @(negedge clk);
                end
                trig = 1'b1;
                repeat (4) @(negedge clk);
            end
        end

        // R6: trigger toggling mid-pulse is ignored
        wr(2'd1, 8'd2);
        wr(2'd2, 8'd8);
        @(negedge clk);
        trig = 1'b0;
        repeat (3) @(negedge clk);
        c = 0;
        for (int i = 0; i < 20; i++) begin
            if (pulse) c++;
            if (i == 1) trig = 1'b1;
            if (i == 3) trig = 1'b0;
            @(negedge clk);
        end
        chk("R6 retrigger ignored", c, 6);
        trig = 1'b1;
        repeat (4) @(negedge clk);

        // R6: trigger ignored in command mode
        wr(2'd0, 8'b0000);
        @(negedge clk);
        trig = 1'b0;
        count_on(12, c);
        chk("R6 trigger in command mode", c, 0);
        trig = 1'b1;
        repeat (4) @(negedge clk);

        // R7: cycle abort
        wr(2'd1, 8'd1);
        wr(2'd2, 8'd10);
        wr(2'd0, 8'b0010);
        repeat (3) @(negedge clk);
        chk("R7 pulse before cut", pulse, 1);
        cut = 1'b1;
        @(negedge clk);
        chk("R7 still on k", pulse, 1);
        @(negedge clk);
        chk("R7 still on k+1", pulse, 1);
        @(negedge clk);
        chk("R7 off at k+2", pulse, 0);
        chk("R7 cut flag set", cflag, 1);
        cut = 1'b0;
        repeat (12) @(negedge clk);
        wr(2'd0, 8'b0010);
        count_on(14, c);
        chk("R7 next pulse normal", c, 9);
        wr(2'd0, 8'b0100);
        chk("R9 cut flag cleared", cflag, 0);

        // R8 / R9: forced off
        wr(2'd0, 8'b0010);
        repeat (3) @(negedge clk);
        chk("R8 pulse before kill", pulse, 1);
        kill = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 off at k+2", pulse, 0);
        chk("R8 kill flag set", kflag, 1);
        kill = 1'b0;
        repeat (12) @(negedge clk);
        wr(2'd0, 8'b0010);
        count_on(14, c);
        chk("R8 no pulse while killed", c, 0);
        chk("R8 kill flag holds", kflag, 1);
        wr(2'd0, 8'b1000);
        chk("R9 kill flag cleared", kflag, 0);
        wr(2'd0, 8'b0010);
        count_on(14, c);
        chk("R9 pulses resume", c, 9);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule